// File: doc/BRIEF.md
# Interrupt Threshold and Status Unit

This block paces the interrupt line of a USB host/device controller. Event sources raise sticky status bits. Each bit stays set until software clears it by writing a one to it. A per-bit enable mask selects which pending bits may request an interrupt. A programmable threshold, counted in micro-frames, sets the minimum spacing between interrupt assertions. A micro-frame tick comes from outside the block, and an interval counter advances on each tick.

The interrupt line rises only when two things are true: an enabled status bit is pending, and the counter has reached the active threshold. The rise restarts the counter and loads the threshold currently held in the command field. A new threshold therefore takes effect at the next restart. Once the line is high, it stays high until software clears every enabled pending bit. Events that arrive while the interval is still running stay pending until it ends.

The register interface has three words. The command word carries the threshold code. The status word is write-one-to-clear. The enable word holds the mask. Reads return data one cycle after the address is presented.

Top module: `usb_irq_pacer`

## Requirements
- R1: After reset, the threshold code is 0x08, status and enable read as zero, and `irq_o` is low.
- R2: The command word is at address 0. The threshold code sits in bits 23:16 and every other bit of the word reads as zero.
- R3: The accepted threshold codes are 0x00, 0x01, 0x02, 0x08, 0x10, 0x20 and 0x40. A command write carrying any other code is ignored and the field keeps its value.
- R4: The status word is at address 1. Writing a one to a bit clears it, and writing zero leaves it unchanged.
- R5: When an event sets a bit in the same cycle that software writes one to clear it, the bit ends up set.
- R6: After reset or after a previous rise, `irq_o` rises only once at least the active threshold's number of micro-frame ticks has arrived. With code 0x00 it rises on the cycle after a bit becomes pending.
- R7: `irq_o` is high only when a status bit is set and its enable bit (enable word, address 2) is also set. Disabled bits stay sticky in status but never raise the line. The line falls on the cycle after the last enabled pending bit is cleared.
- R8: A new threshold code does not change the interval that is currently running. It becomes active when `irq_o` next rises.
- R9: Read data appears on `rd_data` one cycle after `rd_addr` is presented. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uframe_tick | input | 1 | One-cycle pulse per micro-frame |
| evt_set | input | N_SRC | Event pulses, each of which sets its status bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Paced interrupt request |

## Verification
The hardest situation to reach is a threshold change that lands while an interval is already running. In that case the old interval must still govern the next rise, and only the following interval uses the new code. The stimulus reaches it in steps. It first lets the line rise under the reset threshold. It then writes the immediate code, raises an event, and confirms that the line stays low until eight ticks have arrived. After that rise it shows that the next event fires with no ticks at all. The same pattern is repeated for a two-tick code. A collision between an event and a write-one-to-clear on the same bit in the same cycle is also driven deliberately.

// File: rtl/itp_pkg.sv
package itp_pkg;
  localparam int unsigned AW = 2;
  localparam logic [AW-1:0] ADDR_CMD = 2'd0;
  localparam logic [AW-1:0] ADDR_STS = 2'd1;
  localparam logic [AW-1:0] ADDR_EN  = 2'd2;
endpackage

// File: rtl/itp_code_check.sv
module itp_code_check #(
  parameter int unsigned THR_W = 8,
  parameter int unsigned CNT_W = 8,
  // bit i set: code (1<<i) is accepted
  parameter logic [THR_W-1:0] ALLOW_EXP = 8'b0111_1011
) (
  input  logic [THR_W-1:0] code,
  output logic             legal,
  output logic [CNT_W-1:0] interval
);
  always_comb begin
    legal = (code == '0);
    for (int i = 0; i < int'(THR_W); i++) begin
      if (code == THR_W'(1 << i) && ALLOW_EXP[i]) legal = 1'b1;
    end
  end
  assign interval = CNT_W'(code);
endmodule

// File: rtl/itp_interval_timer.sv
module itp_interval_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_THR = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] thr_next,
  output logic             expired,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q, act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= CNT_W'(RST_THR);
    end else if (restart) begin
      cnt_q <= '0;
      act_q <= thr_next;
    end else if (tick && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q >= act_q);
  assign cnt_o   = cnt_q;
  assign act_o   = act_q;
endmodule

// File: rtl/itp_status_bank.sv
module itp_status_bank #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] sts_o
);
  for (genvar b = 0; b < N_SRC; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)           bit_q <= 1'b0;
      else if (set_i[b]) bit_q <= 1'b1;   // set beats clear
      else if (clr_i[b]) bit_q <= 1'b0;
    end
    assign sts_o[b] = bit_q;
  end
endmodule

// File: rtl/usb_irq_pacer.sv
module usb_irq_pacer #(
  parameter int unsigned N_SRC   = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned THR_LSB = 16,
  parameter int unsigned THR_W   = 8,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_THR = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uframe_tick,
  input  logic [N_SRC-1:0]  evt_set,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o
);
  import itp_pkg::*;

  logic [THR_W-1:0] thr_code_q;
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] status;
  logic [N_SRC-1:0] sts_clr;
  logic [THR_W-1:0] wr_code;
  logic             wr_legal;
  logic [CNT_W-1:0] wr_interval;
  logic [CNT_W-1:0] cur_interval;
  logic             cur_legal;
  logic             expired;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act;
  logic             pending;
  logic             irq_q;
  logic             irq_d;
  logic             restart;
  logic [DATA_W-1:0] rd_q;
  logic             unused_inputs;

  assign wr_code = wr_data[THR_LSB +: THR_W];
  assign unused_inputs = ^{wr_data, wr_interval, cur_legal};

  itp_code_check #(.THR_W(THR_W), .CNT_W(CNT_W)) u_wr_chk (
    .code(wr_code), .legal(wr_legal), .interval(wr_interval));

  itp_code_check #(.THR_W(THR_W), .CNT_W(CNT_W)) u_cur_chk (
    .code(thr_code_q), .legal(cur_legal), .interval(cur_interval));

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_code_q <= THR_W'(RST_THR);
      en_q       <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CMD && wr_legal) thr_code_q <= wr_code;
      if (wr_addr == ADDR_EN)              en_q       <= wr_data[N_SRC-1:0];
    end
  end

  assign sts_clr = (wr_en && wr_addr == ADDR_STS) ? wr_data[N_SRC-1:0] : '0;

  itp_status_bank #(.N_SRC(N_SRC)) u_sts (
    .clk(clk), .rst(rst), .set_i(evt_set), .clr_i(sts_clr), .sts_o(status));

  itp_interval_timer #(.CNT_W(CNT_W), .RST_THR(RST_THR)) u_tmr (
    .clk(clk), .rst(rst), .tick(uframe_tick), .restart(restart),
    .thr_next(cur_interval), .expired(expired), .cnt_o(cnt), .act_o(act));

  assign pending = |(status & en_q);
  assign irq_d   = irq_q ? pending : (pending & expired);
  assign restart = irq_d & ~irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_d;
  end
  assign irq_o = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      rd_q <= '0;
      case (rd_addr)
        ADDR_CMD: rd_q[THR_LSB +: THR_W] <= thr_code_q;
        ADDR_STS: rd_q <= DATA_W'(status);
        ADDR_EN:  rd_q <= DATA_W'(en_q);
        default:  rd_q <= '0;
      endcase
    end
  end
  assign rd_data = rd_q;
endmodule

// File: rtl/usb_irq_pacer_chk.sv
module usb_irq_pacer_chk #(
  parameter int unsigned N_SRC   = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned THR_LSB = 16,
  parameter int unsigned THR_W   = 8,
  parameter int unsigned CNT_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [N_SRC-1:0]  evt_set,
  input logic [THR_W-1:0]  thr_code,
  input logic [N_SRC-1:0]  status,
  input logic              pending,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  act,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_o
);
  logic [THR_W-1:0] code_w;
  logic             code_bad;
  logic             unused_chk;
  assign code_w   = wr_data[THR_LSB +: THR_W];
  assign code_bad = !(code_w inside {8'h00, 8'h01, 8'h02, 8'h08, 8'h10, 8'h20, 8'h40});
  assign unused_chk = ^wr_data;

  // R2: bits above the threshold field always read zero
  a_r2_top_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:THR_LSB+THR_W] == '0);

  // R3
  a_r3_rsvd_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0 && code_bad) |=> $stable(thr_code));

  // R4
  a_r4_w1c: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd1) |=> ((status & $past(wr_data[N_SRC-1:0] & ~evt_set)) == '0));

  // R5
  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ((status & $past(evt_set)) == $past(evt_set)));

  // R6: a rise needs the interval to have run out
  a_r6_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(cnt >= act));

  // R6: a rise restarts the count
  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (cnt == '0));

  // R7
  a_r7_needs_pending: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(pending));
endmodule

bind usb_irq_pacer usb_irq_pacer_chk #(
  .N_SRC(N_SRC), .DATA_W(DATA_W), .THR_LSB(THR_LSB), .THR_W(THR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .evt_set(evt_set), .thr_code(thr_code_q), .status(status), .pending(pending),
  .cnt(cnt), .act(act), .rd_data(rd_data), .irq_o(irq_o));

// File: tb/usb_irq_pacer_test.sv
module usb_irq_pacer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        uframe_tick = 1'b0;
  logic [7:0]  evt_set = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_req = 1'b0;
  logic        rd_req_d = 1'b0;

  always #2.5 clk = ~clk;

  usb_irq_pacer uut (
    .clk(clk), .rst(rst), .uframe_tick(uframe_tick), .evt_set(evt_set),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for reads
  always @(posedge clk) rd_req_d <= rd_req;
  always @(negedge clk) begin
    if (rd_req_d && exp_q.size() > 0) chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_expect(input logic [1:0] a, input logic [31:0] e, input string tag);
    rd_addr = a; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic evt(input logic [7:0] v);
    evt_set = v;
    @(negedge clk);
    evt_set = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      uframe_tick = 1'b1;
      @(negedge clk);
      uframe_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  // Both one-cycle pulses are applied together in the same cycle
  task automatic evt_and_clear(input logic [7:0] v);
    evt_set = v; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'(v);
    @(negedge clk);
    evt_set = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk(32'(irq_o), 0, "R1 irq after reset");
    rd_expect(2'd0, 32'h0008_0000, "R1 R2 cmd reset value");
    rd_expect(2'd1, 32'h0, "R1 status reset");
    rd_expect(2'd2, 32'h0, "R1 enable reset");
    rd_expect(2'd3, 32'h0, "R9 unused address");

    // R3: legal and reserved codes
    wr(2'd0, 32'hFF40_FFFF);
    rd_expect(2'd0, 32'h0040_0000, "R2 R3 legal 0x40 with junk bits");
    wr(2'd0, 32'h0004_0000);
    rd_expect(2'd0, 32'h0040_0000, "R3 reserved 0x04 ignored");
    wr(2'd0, 32'h0080_0000);
    rd_expect(2'd0, 32'h0040_0000, "R3 reserved 0x80 ignored");
    wr(2'd0, 32'h0008_0000);
    rd_expect(2'd0, 32'h0008_0000, "R3 back to 0x08");

    wr(2'd2, 32'hFF);
    rd_expect(2'd2, 32'hFF, "R9 enable readback");

    // R6: reset threshold of 8 ticks
    evt(8'h01);
    idle(1);
    chk(32'(irq_o), 0, "R6 no irq before ticks");
    ticks(7);
    chk(32'(irq_o), 0, "R6 no irq after 7 ticks");
    uframe_tick = 1'b1; @(negedge clk); uframe_tick = 1'b0;
    idle(1);
    chk(32'(irq_o), 1, "R6 irq after 8th tick");

    // R4 / R7: clear drops the line
    wr(2'd1, 32'h1);
    idle(1);
    chk(32'(irq_o), 0, "R7 irq falls after clear");
    rd_expect(2'd1, 32'h0, "R4 bit cleared by one");

    // R4: zero bits untouched, R6 interval running
    evt(8'h06);
    wr(2'd1, 32'h2);
    rd_expect(2'd1, 32'h4, "R4 zero write leaves bit 2");
    chk(32'(irq_o), 0, "R6 pending held while interval runs");
    wr(2'd1, 32'h4);

    // R5: set and clear same cycle
    evt_and_clear(8'h08);
    rd_expect(2'd1, 32'h8, "R5 set wins over clear");
    wr(2'd1, 32'h8);
    rd_expect(2'd1, 32'h0, "R4 collision bit cleared later");

    // R7: masking
    wr(2'd2, 32'h7F);
    evt(8'h80);
    ticks(8);
    idle(1);
    chk(32'(irq_o), 0, "R7 masked bit does not raise irq");
    rd_expect(2'd1, 32'h80, "R7 masked bit still sticky");
    wr(2'd2, 32'hFF);
    idle(1);
    chk(32'(irq_o), 1, "R7 enabling pending bit raises irq");
    wr(2'd1, 32'h80);
    idle(1);
    chk(32'(irq_o), 0, "R7 irq falls after clear");

    // R8: immediate code only after next restart
    wr(2'd0, 32'h0000_0000);
    rd_expect(2'd0, 32'h0, "R3 code 0 accepted");
    evt(8'h01);
    idle(2);
    chk(32'(irq_o), 0, "R8 old threshold still in force");
    ticks(8);
    idle(1);
    chk(32'(irq_o), 1, "R8 rise under old threshold");
    wr(2'd1, 32'h1);
    idle(1);
    chk(32'(irq_o), 0, "R7 fall");
    evt(8'h02);
    idle(1);
    chk(32'(irq_o), 1, "R6 immediate code fires without ticks");
    wr(2'd1, 32'h2);
    idle(1);

    // R8 with code 2
    wr(2'd0, 32'h0002_0000);
    evt(8'h04);
    idle(1);
    chk(32'(irq_o), 1, "R8 immediate still active before restart");
    wr(2'd1, 32'h4);
    idle(1);
    chk(32'(irq_o), 0, "R7 fall");
    evt(8'h04);
    idle(2);
    chk(32'(irq_o), 0, "R8 new 2-tick interval applies");
    ticks(1);
    idle(1);
    chk(32'(irq_o), 0, "R6 one tick not enough");
    uframe_tick = 1'b1; @(negedge clk); uframe_tick = 1'b0;
    idle(1);
    chk(32'(irq_o), 1, "R6 irq after 2 ticks");
    wr(2'd1, 32'h4);
    idle(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule